// File: doc/BRIEF.md
# Infrared Pulse-Train Transmitter

This block drives an infrared emitter from a queue of timed entries. Software writes entries into a 128-deep FIFO through a simple register bus. Each entry holds three things: a duration, the timebase that duration is counted in, and a flag that turns the carrier on for the entry. An entry with the flag set is a mark, and the output then carries a square-wave carrier. An entry with the flag clear is a space, and the output then sits at its inactive level. Entries play strictly one after another.

The carrier has a programmable high count and a programmable low count. Both are counted in ticks of a selectable source: the system clock, an external strobe at one third of the crystal rate, or an internal 1 µs or 10 µs tick. The internal ticks come from a prescaler set by the parameter `CYC_PER_US`. An entry can be timed in units of 1 µs, 10 µs, 100 µs, or one full carrier period.

A level-sensitive threshold interrupt tells software when the FIFO has drained far enough to be refilled, so a long frame can be streamed.

Top module: `ir_blaster_tx`

## Requirements
- R1: After reset `ir_out` and `ir_irq` are low, and the control, carrier and threshold registers (byte offsets 0x0, 0x4, 0xC) read 0.
- R2: While no entry is playing, or while the enable bit (control bit 0) is clear, `ir_out` equals the idle-level bit (control bit 2).
- R3: A space entry holds `ir_out` at the idle level for (D+1) units. D is the duration field of the FIFO word (bits 9:0), and the unit comes from bits 11:10: code 0 is 1 µs, code 1 is 10 µs, code 2 is 100 µs. One µs is `CYC_PER_US` clock cycles.
- R4: During a mark entry (FIFO word bit 12 set), `ir_out` is the carrier. The carrier is active for H+1 ticks and then inactive for L+1 ticks, where H is carrier register bits 31:16 and L is bits 15:0. Active means the inverse of the idle level. Every entry restarts the carrier at the start of its active phase.
- R5: Timebase code 3 times an entry in whole carrier periods of H+L+2 ticks.
- R6: Entries play in write order with no gap between them. When the FIFO runs empty, `ir_out` returns to the idle level.
- R7: A write to the FIFO word (offset 0x8) with bit 16 clear stores nothing.
- R8: The pending flag (threshold register bit 16) sets in any cycle where the transmitter is enabled and the FIFO occupancy is at or below the threshold (bits 7:0). Writing the threshold register with bit 16 clear clears the flag, but a set in the same cycle wins. `ir_irq` is the pending flag ANDed with bit 8.
- R9: A FIFO push made while 128 entries are held is dropped and never played. The drop sets a sticky overflow flag, read at threshold register bit 17.
- R10: Control bits 13:12 select the carrier tick: 0 is the system clock, 1 is the `xtal3_tick` strobe, 2 is the 1 µs tick, 3 is the 10 µs tick.
- R11: The control register reads back its bits 13:12, 2 and 0 with all other bits 0. The carrier register reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| xtal3_tick | input | 1 | One-cycle strobe at crystal/3 rate |
| ir_out | output | 1 | Modulated emitter drive |
| ir_irq | output | 1 | Threshold interrupt |

## Verification
The pending flag can be set by the FIFO level condition in the same cycle that a software write clears it. The bench provokes this by writing the clear while the transmitter is enabled and the FIFO is empty below its threshold, and then expects the flag to read back as set. The clear is also repeated with the transmitter disabled, where it must take effect. Mark timing, timebases and carrier restarts are judged from the spacing of `ir_out` transitions, which the bench compares with durations computed from the entry fields.

// File: rtl/ir_blaster_pkg.sv
package ir_blaster_pkg;
  localparam int DUR_W = 10;
  localparam int CAR_W = 16;

  typedef enum logic [1:0] {
    TB_1US     = 2'd0,
    TB_10US    = 2'd1,
    TB_100US   = 2'd2,
    TB_CARRIER = 2'd3
  } ir_tb_e;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_XTAL3 = 2'd1,
    SRC_1US   = 2'd2,
    SRC_10US  = 2'd3
  } ir_src_e;

  typedef struct packed {
    logic             mark;
    ir_tb_e           tb;
    logic [DUR_W-1:0] dur;
  } ir_entry_t;

  localparam int ENTRY_W = $bits(ir_entry_t);
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int CYC_PER_US = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_1us,
  output logic tick_10us
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [3:0]    dec_q, dec_d;

  always_comb begin
    tick_1us  = (pre_q == PW'(CYC_PER_US - 1));
    tick_10us = tick_1us && (dec_q == 4'd9);
    pre_d     = tick_1us ? '0 : pre_q + 1'b1;
    dec_d     = dec_q;
    if (tick_1us) dec_d = (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      dec_q <= '0;
    end else begin
      pre_q <= pre_d;
      dec_q <= dec_d;
    end
  end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] hi_m1,
  input  logic [CNT_W-1:0] lo_m1,
  output logic             wave,
  output logic             period_end
);
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    limit      = phase_q ? hi_m1 : lo_m1;
    period_end = tick && !phase_q && (cnt_q == lo_m1);
    if (restart) begin
      phase_d = 1'b1;
      cnt_d   = '0;
    end else if (tick) begin
      if (cnt_q == limit) begin
        phase_d = ~phase_q;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign wave = phase_q;

  // R4: a restart always begins a fresh active phase
  assert_restart_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q && cnt_q == '0));
endmodule

// File: rtl/ir_fifo.sv
module ir_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 13,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             push_ok, pop_ok;

  always_comb begin
    empty   = (lvl_q == '0);
    full    = (lvl_q == LVL_W'(DEPTH));
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wp_d    = wp_q;
    rp_d    = rp_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    lvl_d = lvl_q + LVL_W'(push_ok) - LVL_W'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  assign rdata = mem[rp_q];
  assign level = lvl_q;

  // R6: the sequencer never consumes from an empty queue
  assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R9: a push into a full queue leaves it full and unchanged
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (lvl_q == LVL_W'(DEPTH) && $stable(wp_q)));
endmodule

// File: rtl/ir_seq.sv
module ir_seq
  import ir_blaster_pkg::*;
#(
  parameter int CYC_PER_US = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      fifo_empty,
  input  ir_entry_t entry,
  input  logic      car_period_end,
  output logic      pop,
  output logic      active,
  output logic      mark
);
  localparam int UNIT_MAX = 100 * CYC_PER_US;
  localparam int UW       = $clog2(UNIT_MAX);

  logic             active_q, active_d, mark_q, mark_d;
  ir_tb_e           tb_q, tb_d;
  logic [DUR_W-1:0] rem_q, rem_d;
  logic [UW-1:0]    ucnt_q, ucnt_d, unit_m1;
  logic             unit_tick, entry_done, load;

  always_comb begin
    case (tb_q)
      TB_1US:   unit_m1 = UW'(CYC_PER_US - 1);
      TB_10US:  unit_m1 = UW'(10 * CYC_PER_US - 1);
      TB_100US: unit_m1 = UW'(100 * CYC_PER_US - 1);
      default:  unit_m1 = '0;
    endcase
    unit_tick  = (tb_q == TB_CARRIER) ? car_period_end : (ucnt_q == unit_m1);
    entry_done = active_q && unit_tick && (rem_q == '0);
    load       = en && !fifo_empty && (!active_q || entry_done);

    active_d = active_q;
    mark_d   = mark_q;
    tb_d     = tb_q;
    rem_d    = rem_q;
    ucnt_d   = ucnt_q;
    if (!en) begin
      active_d = 1'b0;
    end else if (load) begin
      active_d = 1'b1;
      mark_d   = entry.mark;
      tb_d     = entry.tb;
      rem_d    = entry.dur;
      ucnt_d   = '0;
    end else if (entry_done) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (tb_q != TB_CARRIER) ucnt_d = unit_tick ? '0 : ucnt_q + 1'b1;
      if (unit_tick) rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mark_q   <= 1'b0;
      tb_q     <= TB_1US;
      rem_q    <= '0;
      ucnt_q   <= '0;
    end else begin
      active_q <= active_d;
      mark_q   <= mark_d;
      tb_q     <= tb_d;
      rem_q    <= rem_d;
      ucnt_q   <= ucnt_d;
    end
  end

  assign pop    = load;
  assign active = active_q;
  assign mark   = mark_q;

  // R6: an entry in progress keeps playing until its last unit ends
  assert_busy_til_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active_q && !unit_tick) |=> active_q);
endmodule

// File: rtl/ir_blaster_tx.sv
module ir_blaster_tx
  import ir_blaster_pkg::*;
#(
  parameter int CYC_PER_US = 4,
  parameter int FIFO_DEPTH = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        xtal3_tick,
  output logic        ir_out,
  output logic        ir_irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CAR  = 2'd1;
  localparam logic [1:0] IDX_FIFO = 2'd2;
  localparam logic [1:0] IDX_THR  = 2'd3;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic             en_q, en_d, idle_q, idle_d;
  ir_src_e          src_q, src_d;
  logic [CAR_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [7:0]       thr_q, thr_d;
  logic             irqen_q, irqen_d, pend_q, pend_d, ovf_q, ovf_d;
  logic             out_q, out_d;

  logic             wr_ctrl, wr_car, wr_fifo, wr_thr, push_req, set_pend;
  logic             tick_1us, tick_10us, car_tick, car_wave, car_pend;
  logic             fifo_empty, fifo_full, seq_pop, seq_active, seq_mark;
  logic [LVL_W-1:0] fifo_level;
  ir_entry_t        wr_entry, rd_entry;
  logic             unused_addr;

  assign unused_addr = ^bus_addr[1:0];

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr[3:2] == IDX_CTRL);
    wr_car   = bus_wr && (bus_addr[3:2] == IDX_CAR);
    wr_fifo  = bus_wr && (bus_addr[3:2] == IDX_FIFO);
    wr_thr   = bus_wr && (bus_addr[3:2] == IDX_THR);
    push_req = wr_fifo && bus_wdata[16];
    wr_entry = '{mark: bus_wdata[12], tb: ir_tb_e'(bus_wdata[11:10]),
                 dur: bus_wdata[DUR_W-1:0]};
    set_pend = en_q && (int'(fifo_level) <= int'(thr_q));

    en_d    = wr_ctrl ? bus_wdata[0] : en_q;
    idle_d  = wr_ctrl ? bus_wdata[2] : idle_q;
    src_d   = wr_ctrl ? ir_src_e'(bus_wdata[13:12]) : src_q;
    hi_d    = wr_car ? bus_wdata[31:16] : hi_q;
    lo_d    = wr_car ? bus_wdata[15:0] : lo_q;
    thr_d   = wr_thr ? bus_wdata[7:0] : thr_q;
    irqen_d = wr_thr ? bus_wdata[8] : irqen_q;
    pend_d  = pend_q;
    if (set_pend) pend_d = 1'b1;
    else if (wr_thr && !bus_wdata[16]) pend_d = 1'b0;
    ovf_d   = ovf_q | (push_req && fifo_full);

    case (src_q)
      SRC_SYS:   car_tick = 1'b1;
      SRC_XTAL3: car_tick = xtal3_tick;
      SRC_1US:   car_tick = tick_1us;
      default:   car_tick = tick_10us;
    endcase

    out_d = (en_q && seq_active && seq_mark) ? (car_wave ^ idle_q) : idle_q;

    case (bus_addr[3:2])
      IDX_CTRL: bus_rdata = {18'd0, src_q, 9'd0, idle_q, 1'b0, en_q};
      IDX_CAR:  bus_rdata = {hi_q, lo_q};
      IDX_THR:  bus_rdata = {14'd0, ovf_q, pend_q, 7'd0, irqen_q, thr_q};
      default:  bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      idle_q  <= 1'b0;
      src_q   <= SRC_SYS;
      hi_q    <= '0;
      lo_q    <= '0;
      thr_q   <= '0;
      irqen_q <= 1'b0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      idle_q  <= idle_d;
      src_q   <= src_d;
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      thr_q   <= thr_d;
      irqen_q <= irqen_d;
      pend_q  <= pend_d;
      ovf_q   <= ovf_d;
      out_q   <= out_d;
    end
  end

  assign ir_out = out_q;
  assign ir_irq = pend_q && irqen_q;

  ir_tick_gen #(.CYC_PER_US(CYC_PER_US)) i_ticks (
    .clk(clk), .rst_n(rst_sync_n), .tick_1us(tick_1us), .tick_10us(tick_10us));

  ir_carrier_gen #(.CNT_W(CAR_W)) i_carrier (
    .clk(clk), .rst_n(rst_sync_n), .tick(car_tick), .restart(seq_pop),
    .hi_m1(hi_q), .lo_m1(lo_q), .wave(car_wave), .period_end(car_pend));

  ir_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W), .LVL_W(LVL_W)) i_fifo (
    .clk(clk), .rst_n(rst_sync_n), .push(push_req), .wdata(wr_entry),
    .pop(seq_pop), .rdata(rd_entry), .empty(fifo_empty), .full(fifo_full),
    .level(fifo_level));

  ir_seq #(.CYC_PER_US(CYC_PER_US)) i_seq (
    .clk(clk), .rst_n(rst_sync_n), .en(en_q), .fifo_empty(fifo_empty),
    .entry(rd_entry), .car_period_end(car_pend), .pop(seq_pop),
    .active(seq_active), .mark(seq_mark));

  // R2: with the transmitter off the pin settles at the idle level
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_q |=> (ir_out == $past(idle_q)));
  // R8: pending only rises from an enabled, low-occupancy cycle
  assert_pend_cause_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pend_q) |-> $past(en_q && (int'(fifo_level) <= int'(thr_q))));
  // R9: overflow is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ovf_q |=> ovf_q);
  // R4: each loaded entry starts the carrier in its active phase
  assert_mark_starts_high_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seq_pop |=> car_wave);
endmodule

// File: tb/test_ir_blaster_tx.sv
`timescale 1ns/1ps
module test_ir_blaster_tx;
  localparam int CPU = 2;
  localparam logic [3:0] A_CTRL = 4'h0, A_CAR = 4'h4, A_FIFO = 4'h8, A_THR = 4'hC;

  logic        clk, rst_n, bus_wr, xtal3_tick, ir_out, ir_irq;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int tq[$];
  logic [31:0] ents[$];
  logic prev_out = 1'b0;

  ir_blaster_tx #(.CYC_PER_US(CPU), .FIFO_DEPTH(128)) i_ir_blaster_tx (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xtal3_tick(xtal3_tick),
    .ir_out(ir_out), .ir_irq(ir_irq));

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial begin
    xtal3_tick = 1'b0;
    forever begin
      @(negedge clk); xtal3_tick = 1'b1;
      @(negedge clk); xtal3_tick = 1'b0;
      @(negedge clk);
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (ir_out !== prev_out) begin
      tq.push_back(cyc);
      prev_out = ir_out;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gap(input int i);
    if (i + 1 < tq.size()) return tq[i+1] - tq[i];
    return -1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic clear_log();
    wait_cyc(2);
    #1 tq.delete();
  endtask

  task automatic start_frame(input logic [31:0] ctrl, input logic [31:0] car);
    bus_write(A_CTRL, ctrl & ~32'h1);
    bus_write(A_CAR, car);
    foreach (ents[i]) bus_write(A_FIFO, ents[i]);
    clear_log();
    bus_write(A_CTRL, ctrl | 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 ir_out after reset", ir_out, 0);
    check("R1 irq after reset", ir_irq, 0);
    bus_read(A_CTRL, d); check("R1 ctrl reset", d, 0);
    bus_read(A_CAR, d);  check("R1 carrier reset", d, 0);
    bus_read(A_THR, d);  check("R1 threshold reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    bus_read(A_CTRL, d); check("R11 ctrl readback", d, 32'h3005);
    bus_write(A_CAR, 32'h1234_5678);
    bus_read(A_CAR, d);  check("R11 carrier readback", d, 32'h1234_5678);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_mark_space();
    ents = {32'h11C00, 32'h10004, 32'h11C00};
    start_frame(32'h0, {16'd2, 16'd2});
    wait_cyc(60);
    check("R6 transition count", tq.size(), 4);
    check("R5 mark one period high", gap(0), 3);
    check("R3 low + 1us space", gap(1), 13);
    check("R6 second mark high", gap(2), 3);
    check("R6 idle after drain", ir_out, 0);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_inverted();
    bus_write(A_CTRL, 32'h4);
    wait_cyc(3);
    check("R2 idle high while disabled", ir_out, 1);
    ents = {32'h11C01};
    start_frame(32'h4, {16'd3, 16'd1});
    wait_cyc(40);
    check("R5 two periods transitions", tq.size(), 4);
    check("R4 inverted active phase", gap(0), 4);
    check("R4 inverted inactive phase", gap(1), 2);
    check("R4 second active phase", gap(2), 4);
    check("R2 idle high after frame", ir_out, 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_timebases();
    ents = {32'h11C00, 32'h10402, 32'h11C00, 32'h10800, 32'h11C00};
    start_frame(32'h0, 32'h0);
    wait_cyc(320);
    check("R3 timebase transitions", tq.size(), 6);
    check("R3 10us space x3", gap(1), 61);
    check("R3 100us space x1", gap(3), 201);
    check("R6 final mark", gap(4), 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_restart();
    ents = {32'h11004, 32'h11000};
    start_frame(32'h0, {16'd1, 16'd1});
    wait_cyc(40);
    check("R4 restart transitions", tq.size(), 6);
    check("R4 first active", gap(0), 2);
    check("R4 inactive", gap(1), 2);
    check("R4 restart merges active", gap(4), 4);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_sources();
    ents = {32'h11800};
    start_frame(32'h1000, {16'd1, 16'd0});
    wait_cyc(260);
    check("R10 xtal3 low phase", gap(1), 3);
    check("R10 xtal3 high phase", gap(2), 6);
    bus_write(A_CTRL, 32'h0);
    ents = {32'h11800};
    start_frame(32'h2000, {16'd1, 16'd0});
    wait_cyc(260);
    check("R10 1us low phase", gap(1), 2);
    check("R10 1us high phase", gap(2), 4);
    bus_write(A_CTRL, 32'h0);
    ents = {32'h11800};
    start_frame(32'h3000, 32'h0);
    wait_cyc(260);
    check("R10 10us phase a", gap(1), 20);
    check("R10 10us phase b", gap(2), 20);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_no_push();
    bus_write(A_CAR, 32'h0);
    bus_write(A_CTRL, 32'h1);
    clear_log();
    bus_write(A_FIFO, 32'h0000_1C05);
    wait_cyc(50);
    check("R7 unflagged write stores nothing", tq.size(), 0);
    bus_write(A_FIFO, 32'h0001_1C00);
    wait_cyc(20);
    check("R7 only real entry plays", tq.size(), 2);
    check("R7 real entry width", gap(0), 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    bus_write(A_THR, 32'h101);
    bus_read(A_THR, d); check("R8 cleared while disabled", d, 32'h101);
    check("R8 irq low", ir_irq, 0);
    ents = {32'h11009, 32'h11009, 32'h11009};
    start_frame(32'h0, 32'h0);
    wait_cyc(5);
    check("R8 no irq above threshold", ir_irq, 0);
    wait_cyc(100);
    check("R8 irq at threshold", ir_irq, 1);
    bus_write(A_THR, 32'h101);
    bus_read(A_THR, d); check("R8 set wins over clear", d, 32'h10101);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_THR, 32'h101);
    bus_read(A_THR, d); check("R8 clear when disabled", d, 32'h101);
    check("R8 irq drops", ir_irq, 0);
    bus_write(A_CTRL, 32'h1);
    bus_write(A_THR, 32'h001);
    bus_read(A_THR, d); check("R8 pending with irq off", d, 32'h10001);
    check("R8 irq masked", ir_irq, 0);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_THR, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    bus_write(A_CAR, 32'h0);
    for (int i = 0; i < 127; i++) bus_write(A_FIFO, 32'h10000);
    bus_write(A_FIFO, 32'h11C00);
    bus_read(A_THR, d); check("R9 no overflow at 128", (d >> 17) & 1, 0);
    bus_write(A_FIFO, 32'h11C00);
    bus_read(A_THR, d); check("R9 overflow flag", (d >> 17) & 1, 1);
    clear_log();
    bus_write(A_CTRL, 32'h1);
    wait_cyc(400);
    check("R9 dropped entry not played", tq.size(), 2);
    check("R9 kept mark width", gap(0), 1);
    bus_write(A_CTRL, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regs();
    t_mark_space();
    t_inverted();
    t_timebases();
    t_restart();
    t_sources();
    t_no_push();
    t_threshold();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule